// File: doc/BRIEF.md
# Configuration Identifier Write-Unlock Sequencer

This block holds a 32-bit subsystem identifier that sits in a PCI-style configuration space. Software sees the identifier as a read-only dword. It can be replaced only through a separate access port, and only after a three-byte key has been written to that port in the right order. A correct key opens a window that accepts exactly one write. That write replaces the identifier, byte lane by byte lane, and shuts the window again. The identifier is then read back at its normal read-only offset.

A strap input is captured while reset is held. When the strap is low the unlock mechanism is live. When it is high the access port ignores every write. A value from nonvolatile storage can be loaded with a valid flag at any time. Because of that, a value loaded after power-up can still be overridden by the key sequence. The lock returns to its initial state on a bus reset. It also returns there on any read of the access port once a key byte has been taken, on any write carrying the wrong key byte, and after the single identifier write.

Top module: `sysid_guard`

## Requirements
- R1: The strap level present on `strap_n` while `rst` is high is held after reset. Low enables the mechanism. High makes the access port ignore all writes, so the identifier changes only by preload.
- R2: The access port is the dword at byte address 0x48. The key is 0x53, then 0x59, then 0x4D, each carried in bits 7:0 with `cfg_be[0]` set. Bits 31:8 and their enables are ignored. The third key byte opens the write window.
- R3: The first port write in the open window updates each identifier byte whose enable is set (lane n = bits 8n+7:8n) and keeps the other bytes. The same write re-locks the port, so a later write without a new key has no effect.
- R4: In the key phase, a port write whose bits 7:0 are not the next key byte, or whose `cfg_be[0]` is clear, re-locks the port. If that byte is 0x53 (with `cfg_be[0]` set), it counts as the first key byte.
- R5: A port read re-locks the port from any key state or from the open window. Port reads always return zero.
- R6: After reset the lock is in its initial state, the identifier equals parameter `ID_RST` (default 0xA5A50001), and `cfg_rdata` is zero.
- R7: A read of byte address 0x2C returns the identifier on `cfg_rdata` one cycle after the `cfg_rd` strobe. Reads of any other address return zero. `cfg_rdata` is zero in a cycle that follows no read.
- R8: `pre_vld` loads all of `pre_val` into the identifier. If `pre_vld` coincides with the window write, the enabled lanes take the write data and the other lanes take `pre_val`.
- R9: If a port read and a port write occur in the same cycle, the read takes priority. The port re-locks and the identifier is not written.
- R10: The sequence can be repeated from the first key byte to change the identifier again. `id_out` always shows the current identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high bus reset |
| strap_n | input | 1 | Enable strap, low enables, captured during reset |
| pre_val | input | 32 | Value from nonvolatile storage |
| pre_vld | input | 1 | Load strobe for `pre_val` |
| cfg_addr | input | 8 | Configuration byte address (dword aligned) |
| cfg_be | input | 4 | Byte lane enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rd | input | 1 | Read strobe |
| cfg_wr | input | 1 | Write strobe |
| id_out | output | 32 | Current identifier |
| cfg_rdata | output | 32 | Registered read data |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the preload strobe and the window write. The bench opens the window and raises `pre_vld` together with a partial-lane port write. The result must merge: the enabled bytes come from the write and the rest from the preload. The second pair is a port read and a port write. The bench strobes `cfg_rd` and `cfg_wr` together on 0x48 while the window is open. It then expects the identifier to be unchanged, and it expects a follow-up write without a new key to be ignored as well.

// File: rtl/sysid_pkg.sv
package sysid_pkg;

  // Progress through the unlock key
  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_GOT1   = 2'd1,
    KS_GOT2   = 2'd2,
    KS_OPEN   = 2'd3
  } key_state_t;

  localparam int unsigned LANE_W = 8;

endpackage

// File: rtl/sysid_addr_dec.sv
module sysid_addr_dec #(
  parameter int unsigned          ADDR_W   = 8,
  parameter logic [ADDR_W-1:0]    PORT_OFS = 8'h48,
  parameter logic [ADDR_W-1:0]    ID_OFS   = 8'h2C
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_port,
  output logic              hit_id
);

  // Dword granularity: drop the two byte-offset bits
  localparam int unsigned DW_LSB = 2;

  always_comb begin
    hit_port = (addr[ADDR_W-1:DW_LSB] == PORT_OFS[ADDR_W-1:DW_LSB]);
    hit_id   = (addr[ADDR_W-1:DW_LSB] == ID_OFS[ADDR_W-1:DW_LSB]);
  end

endmodule

// File: rtl/sysid_key_fsm.sv
module sysid_key_fsm
  import sysid_pkg::*;
#(
  parameter logic [LANE_W-1:0] KEY_A = 8'h53,
  parameter logic [LANE_W-1:0] KEY_B = 8'h59,
  parameter logic [LANE_W-1:0] KEY_C = 8'h4D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              port_wr,
  input  logic              port_rd,
  input  logic              key_vld,
  input  logic [LANE_W-1:0] key_byte,
  output key_state_t        state,
  output logic              commit
);

  key_state_t nxt;
  logic       is_a;
  logic       is_b;
  logic       is_c;

  always_comb begin
    is_a = key_vld && (key_byte == KEY_A);
    is_b = key_vld && (key_byte == KEY_B);
    is_c = key_vld && (key_byte == KEY_C);
  end

  always_comb begin
    nxt    = state;
    commit = 1'b0;
    if (en) begin
      if (port_rd) begin
        nxt = KS_LOCKED;
      end else if (port_wr) begin
        unique case (state)
          KS_LOCKED: nxt = is_a ? KS_GOT1 : KS_LOCKED;
          KS_GOT1: begin
            if (is_b)      nxt = KS_GOT2;
            else if (is_a) nxt = KS_GOT1;
            else           nxt = KS_LOCKED;
          end
          KS_GOT2: begin
            if (is_c)      nxt = KS_OPEN;
            else if (is_a) nxt = KS_GOT1;
            else           nxt = KS_LOCKED;
          end
          KS_OPEN: begin
            commit = 1'b1;
            nxt    = KS_LOCKED;
          end
          default: nxt = KS_LOCKED;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= KS_LOCKED;
    else     state <= nxt;
  end

endmodule

// File: rtl/sysid_store.sv
module sysid_store
  import sysid_pkg::*;
#(
  parameter int unsigned        DATA_W = 32,
  parameter logic [DATA_W-1:0]  ID_RST = 32'hA5A5_0001
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       pre_vld,
  input  logic [DATA_W-1:0]          pre_val,
  input  logic                       commit,
  input  logic [DATA_W/LANE_W-1:0]   be,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          id_q
);

  localparam int unsigned LANES = DATA_W / LANE_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        id_q[l*LANE_W +: LANE_W] <= ID_RST[l*LANE_W +: LANE_W];
      else if (commit && be[l])
        id_q[l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
      else if (pre_vld)
        id_q[l*LANE_W +: LANE_W] <= pre_val[l*LANE_W +: LANE_W];
    end
  end

endmodule

// File: rtl/sysid_guard.sv
module sysid_guard
  import sysid_pkg::*;
#(
  parameter int unsigned        ADDR_W   = 8,
  parameter int unsigned        DATA_W   = 32,
  parameter logic [ADDR_W-1:0]  PORT_OFS = 8'h48,
  parameter logic [ADDR_W-1:0]  ID_OFS   = 8'h2C,
  parameter logic [DATA_W-1:0]  ID_RST   = 32'hA5A5_0001
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      strap_n,
  input  logic [DATA_W-1:0]         pre_val,
  input  logic                      pre_vld,
  input  logic [ADDR_W-1:0]         cfg_addr,
  input  logic [DATA_W/LANE_W-1:0]  cfg_be,
  input  logic [DATA_W-1:0]         cfg_wdata,
  input  logic                      cfg_rd,
  input  logic                      cfg_wr,
  output logic [DATA_W-1:0]         id_out,
  output logic [DATA_W-1:0]         cfg_rdata
);

  logic        en_q;
  logic        hit_port;
  logic        hit_id;
  logic        port_wr;
  logic        port_rd;
  logic        commit;
  key_state_t  st;
  logic [DATA_W-1:0] id_q;

  // Strap is captured for as long as reset is held
  always_ff @(posedge clk) begin
    if (rst) en_q <= ~strap_n;
  end

  sysid_addr_dec #(
    .ADDR_W   (ADDR_W),
    .PORT_OFS (PORT_OFS),
    .ID_OFS   (ID_OFS)
  ) u_dec (
    .addr     (cfg_addr),
    .hit_port (hit_port),
    .hit_id   (hit_id)
  );

  always_comb begin
    port_wr = cfg_wr && hit_port;
    port_rd = cfg_rd && hit_port;
  end

  sysid_key_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .en       (en_q),
    .port_wr  (port_wr),
    .port_rd  (port_rd),
    .key_vld  (cfg_be[0]),
    .key_byte (cfg_wdata[LANE_W-1:0]),
    .state    (st),
    .commit   (commit)
  );

  sysid_store #(
    .DATA_W (DATA_W),
    .ID_RST (ID_RST)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .pre_vld (pre_vld),
    .pre_val (pre_val),
    .commit  (commit),
    .be      (cfg_be),
    .wdata   (cfg_wdata),
    .id_q    (id_q)
  );

  assign id_out = id_q;

  always_ff @(posedge clk) begin
    if (rst)                   cfg_rdata <= '0;
    else if (cfg_rd && hit_id) cfg_rdata <= id_q;
    else                       cfg_rdata <= '0;
  end

endmodule

// File: rtl/sysid_guard_chk.sv
module sysid_guard_chk
  import sysid_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_q,
  input  logic              pre_vld,
  input  logic              port_rd,
  input  logic              port_wr,
  input  logic              cfg_rd,
  input  logic              commit,
  input  key_state_t        st,
  input  logic [DATA_W-1:0] id_out,
  input  logic [DATA_W-1:0] cfg_rdata
);

  // R1
  strap_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !pre_vld) |=> $stable(id_out));

  // R2
  open_order_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(st == KS_OPEN) |-> ($past(st) == KS_GOT2));

  // R3
  one_shot_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> (st == KS_LOCKED));

  // R5
  read_relock_chk: assert property (@(posedge clk) disable iff (rst)
    (port_rd && en_q) |=> (st == KS_LOCKED));

  // R7
  idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_rd |=> (cfg_rdata == '0));

  // R9
  rd_beats_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (port_rd && port_wr && !pre_vld) |=> $stable(id_out));

endmodule

bind sysid_guard sysid_guard_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en_q      (en_q),
  .pre_vld   (pre_vld),
  .port_rd   (port_rd),
  .port_wr   (port_wr),
  .cfg_rd    (cfg_rd),
  .commit    (commit),
  .st        (st),
  .id_out    (id_out),
  .cfg_rdata (cfg_rdata)
);

// File: tb/sysid_guard_bench.sv
module sysid_guard_bench;

  localparam logic [31:0] ID_RST = 32'hA5A5_0001;
  localparam logic [7:0]  PORT   = 8'h48;
  localparam logic [7:0]  IDA    = 8'h2C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strap_n = 1'b0;
  logic [31:0] pre_val = '0;
  logic        pre_vld = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_rd = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] id_out;
  logic [31:0] cfg_rdata;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  logic [31:0] model;

  always #5 clk = ~clk;

  sysid_guard u_sysid_guard (
    .clk       (clk),
    .rst       (rst),
    .strap_n   (strap_n),
    .pre_val   (pre_val),
    .pre_vld   (pre_vld),
    .cfg_addr  (cfg_addr),
    .cfg_be    (cfg_be),
    .cfg_wdata (cfg_wdata),
    .cfg_rd    (cfg_rd),
    .cfg_wr    (cfg_wr),
    .id_out    (id_out),
    .cfg_rdata (cfg_rdata)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic do_reset(logic s);
    @(negedge clk);
    rst = 1'b1; strap_n = s;
    repeat (2) @(negedge clk);
    rst = 1'b0; strap_n = 1'b0;
    model = ID_RST;
  endtask

  task automatic wr(logic [7:0] a, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_rd = 1'b1;
    @(negedge clk);
    cfg_rd = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic key3();
    wr(PORT, 4'h1, 32'h53);
    wr(PORT, 4'h1, 32'h59);
    wr(PORT, 4'h1, 32'h4D);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset(1'b0);
    check("R6 id after reset", id_out, ID_RST);
    check("R6 rdata after reset", cfg_rdata, 32'h0);
    rd(IDA, d);
    check("R7 read id offset", d, ID_RST);
    rd(8'h10, d);
    check("R7 other offset reads zero", d, 32'h0);
    @(negedge clk);
    check("R7 rdata idle zero", cfg_rdata, 32'h0);
  endtask

  task automatic t_unlock_full();
    logic [31:0] d;
    key3();
    wr(PORT, 4'hF, 32'h1234_5678);
    check("R2 full key opens window", id_out, 32'h1234_5678);
    rd(IDA, d);
    check("R7 readback new id", d, 32'h1234_5678);
    wr(PORT, 4'hF, 32'hDEAD_BEEF);
    check("R3 second write ignored", id_out, 32'h1234_5678);
  endtask

  task automatic t_lanes();
    key3();
    wr(PORT, 4'b0101, 32'hAABB_CCDD);
    check("R3 lane merge", id_out, 32'h12BB_56DD);
  endtask

  task automatic t_wrong_key();
    wr(PORT, 4'h1, 32'h53);
    wr(PORT, 4'h1, 32'h00);
    wr(PORT, 4'h1, 32'h59);
    wr(PORT, 4'h1, 32'h4D);
    wr(PORT, 4'hF, 32'h0BAD_0BAD);
    check("R4 wrong key relocks", id_out, 32'h12BB_56DD);
    wr(PORT, 4'h1, 32'h53);
    wr(PORT, 4'h2, 32'h5900);
    wr(PORT, 4'h1, 32'h4D);
    wr(PORT, 4'hF, 32'h0BAD_0BAD);
    check("R4 key without lane0 enable relocks", id_out, 32'h12BB_56DD);
  endtask

  task automatic t_restart_53();
    wr(PORT, 4'h1, 32'h53);
    wr(PORT, 4'h1, 32'h53);
    wr(PORT, 4'h1, 32'h59);
    wr(PORT, 4'h1, 32'h4D);
    wr(PORT, 4'hF, 32'h0000_0053);
    check("R4 repeated first byte restarts", id_out, 32'h0000_0053);
  endtask

  task automatic t_read_relock();
    logic [31:0] d;
    wr(PORT, 4'h1, 32'h53);
    wr(PORT, 4'h1, 32'h59);
    rd(PORT, d);
    check("R5 port read returns zero", d, 32'h0);
    wr(PORT, 4'h1, 32'h4D);
    wr(PORT, 4'hF, 32'hFFFF_0000);
    check("R5 read mid-key relocks", id_out, 32'h0000_0053);
    key3();
    rd(PORT, d);
    wr(PORT, 4'hF, 32'hFFFF_0000);
    check("R5 read in window relocks", id_out, 32'h0000_0053);
  endtask

  task automatic t_wide_key();
    wr(PORT, 4'hF, 32'hFFEE_DD53);
    wr(PORT, 4'h3, 32'h7777_1159);
    wr(PORT, 4'hF, 32'h0102_034D);
    wr(PORT, 4'hF, 32'hC0DE_0010);
    check("R2 upper lanes ignored in key", id_out, 32'hC0DE_0010);
  endtask

  task automatic t_preload();
    @(negedge clk);
    pre_val = 32'h1111_2222; pre_vld = 1'b1;
    @(negedge clk);
    pre_vld = 1'b0;
    check("R8 preload applied", id_out, 32'h1111_2222);
    key3();
    @(negedge clk);
    cfg_addr = PORT; cfg_be = 4'b1001; cfg_wdata = 32'h99AA_BB88; cfg_wr = 1'b1;
    pre_val = 32'h3344_5566; pre_vld = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; pre_vld = 1'b0; cfg_be = '0;
    check("R8 preload and write same cycle", id_out, 32'h9944_5588);
    key3();
    wr(PORT, 4'hF, 32'h5555_AAAA);
    check("R10 sequence repeats", id_out, 32'h5555_AAAA);
  endtask

  task automatic t_rd_wr_same();
    key3();
    @(negedge clk);
    cfg_addr = PORT; cfg_be = 4'hF; cfg_wdata = 32'h0F0F_0F0F;
    cfg_wr = 1'b1; cfg_rd = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_rd = 1'b0;
    check("R9 read wins over write", id_out, 32'h5555_AAAA);
    wr(PORT, 4'hF, 32'h0F0F_0F0F);
    check("R9 window closed after collision", id_out, 32'h5555_AAAA);
  endtask

  task automatic t_bus_reset();
    wr(PORT, 4'h1, 32'h53);
    wr(PORT, 4'h1, 32'h59);
    do_reset(1'b0);
    check("R6 reset restores id", id_out, ID_RST);
    wr(PORT, 4'h1, 32'h4D);
    wr(PORT, 4'hF, 32'h7777_7777);
    check("R6 reset clears key progress", id_out, ID_RST);
  endtask

  task automatic t_strap();
    do_reset(1'b1);
    key3();
    wr(PORT, 4'hF, 32'h2468_ACE0);
    check("R1 strap high blocks writes", id_out, ID_RST);
    @(negedge clk);
    pre_val = 32'h1357_9BDF; pre_vld = 1'b1;
    @(negedge clk);
    pre_vld = 1'b0;
    check("R1 preload still works when disabled", id_out, 32'h1357_9BDF);
    do_reset(1'b0);
    key3();
    wr(PORT, 4'hF, 32'h2468_ACE0);
    check("R1 strap low enables", id_out, 32'h2468_ACE0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_unlock_full();
    t_lanes();
    t_wrong_key();
    t_restart_53();
    t_read_relock();
    t_wide_key();
    t_preload();
    t_rd_wr_same();
    t_bus_reset();
    t_strap();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule